// File: doc/BRIEF.md
# Parallel-Prefix Carry Adder

This block is a purely combinational adder of `WIDTH` bits whose carries come from a parallel prefix network. Each bit first forms a generate/propagate pair. A tree of combining cells then merges these pairs into group generates that run from the carry-in up to every bit position. The carry-in is treated as an extra stage below bit 0. That stage has propagate 0 and generate equal to `carry_in`, and it is merged into bit 0 before the tree. The group generate ending at bit i is the carry out of bit i.

The combining cell takes a lower region (gl, pl) and an upper region (gh, ph) and returns (gh | gl&ph, pl&ph). This operator is associative but not commutative. Each tree may therefore regroup cells, but it always feeds the lower region into the lower input. The parameter `ARCH` selects one of two tree shapes. The first is a log-depth full tree with a doubling span at every level. The second is a sparser up-sweep/down-sweep tree with about twice the depth and roughly 2·WIDTH cells. The sum bit i is the bit propagate XOR the carry into bit i. The carry-out is the group generate over every stage. The vector of group generates is exported so that neighbouring logic can use early carries.

Top module: `prefix_adder`

## Requirements
- R1: `sum_o` equals the low `WIDTH` bits of `op_a + op_b + carry_in`, taken as unsigned.
- R2: `carry_out` equals bit `WIDTH` of `op_a + op_b + carry_in`.
- R3: `grp_gen[i]` equals the carry produced out of bit i. This is bit i+1 of the unsigned sum of `op_a[i:0]`, `op_b[i:0]` and `carry_in`.
- R4: `grp_gen[0]` equals `(op_a[0] & op_b[0]) | ((op_a[0] ^ op_b[0]) & carry_in)`. The carry-in behaves as a stage below bit 0 with propagate 0, so no prefix ever has propagate 1.
- R5: For i ≥ 1, `grp_gen[i]` equals `(op_a[i] & op_b[i]) | ((op_a[i] ^ op_b[i]) & grp_gen[i-1])`.
- R6: When `op_a ^ op_b` is all ones, every bit of `grp_gen` equals `carry_in`, and `sum_o` is all ones when `carry_in` is 0 or all zeros when it is 1.
- R7: Both `ARCH` settings (0 = log-depth full tree, 1 = up/down-sweep tree) give bit-identical `sum_o`, `carry_out` and `grp_gen` for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |
| grp_gen | output | WIDTH | Group generate from the carry-in stage through bit i |

## Verification
The assertions only evaluate the block once its inputs have settled. They assume the operands and carry-in are two-valued, because they compare the outputs against arithmetic on those same inputs. The bench keeps within this by driving the inputs only at the rising edge and sampling at the falling edge. It also sweeps every operand pair and carry-in of an 8-bit configuration. One instance of each tree shape sees the same inputs, so the two shapes can be compared with each other. Each is also checked against a plain sum and against a bit-serial ripple model of the carries.

// File: rtl/prefix_pkg.sv
package prefix_pkg;

    // One generate/propagate pair for a bit or a contiguous group of bits.
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Tree shape selection.
    localparam int unsigned NET_FULL  = 0;
    localparam int unsigned NET_SWEEP = 1;

    // Merge a lower region with the upper region directly above it.
    // Argument order matters: the operator is not commutative.
    function automatic gp_t gp_merge(input gp_t lo, input gp_t hi);
        gp_t r;
        r.g = hi.g | (lo.g & hi.p);
        r.p = lo.p & hi.p;
        return r;
    endfunction

endpackage

// File: rtl/bit_gp_gen.sv
module bit_gp_gen #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] bit_p,
    output logic [WIDTH-1:0] leaf_g,
    output logic [WIDTH-1:0] leaf_p
);
    import prefix_pkg::*;

    assign bit_p = op_a ^ op_b;

    // Bit 0 absorbs the carry-in stage (g = carry_in, p = 0) ahead of the tree.
    gp_t cin_stage;
    gp_t bit0_raw;
    assign cin_stage = '{g: carry_in, p: 1'b0};
    assign bit0_raw  = '{g: op_a[0] & op_b[0], p: bit_p[0]};
    assign {leaf_g[0], leaf_p[0]} = gp_merge(cin_stage, bit0_raw);

    for (genvar i = 1; i < WIDTH; i++) begin : g_leaf
        assign leaf_g[i] = op_a[i] & op_b[i];
        assign leaf_p[i] = bit_p[i];
    end

endmodule

// File: rtl/full_prefix_net.sv
module full_prefix_net #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] in_g,
    input  logic [WIDTH-1:0] in_p,
    output logic [WIDTH-1:0] out_g,
    output logic [WIDTH-1:0] out_p
);
    import prefix_pkg::*;

    localparam int unsigned LEVELS = $clog2(WIDTH);

    logic [WIDTH-1:0] lg [LEVELS+1];
    logic [WIDTH-1:0] lp [LEVELS+1];

    assign lg[0] = in_g;
    assign lp[0] = in_p;

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int unsigned SPAN = 1 << l;
        for (genvar i = 0; i < WIDTH; i++) begin : g_node
            if (i >= SPAN) begin : g_cell
                assign {lg[l+1][i], lp[l+1][i]} = gp_merge(
                    gp_t'{g: lg[l][i-SPAN], p: lp[l][i-SPAN]},
                    gp_t'{g: lg[l][i],      p: lp[l][i]});
            end else begin : g_wire
                assign lg[l+1][i] = lg[l][i];
                assign lp[l+1][i] = lp[l][i];
            end
        end
    end

    assign out_g = lg[LEVELS];
    assign out_p = lp[LEVELS];

endmodule

// File: rtl/sweep_prefix_net.sv
module sweep_prefix_net #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] in_g,
    input  logic [WIDTH-1:0] in_p,
    output logic [WIDTH-1:0] out_g,
    output logic [WIDTH-1:0] out_p
);
    import prefix_pkg::*;

    localparam int unsigned LEVELS = $clog2(WIDTH);
    localparam int unsigned DOWN   = (LEVELS > 1) ? LEVELS - 1 : 0;

    // Up-sweep: binary reduction onto nodes whose index+1 is a multiple of the step.
    logic [WIDTH-1:0] ug [LEVELS+1];
    logic [WIDTH-1:0] up [LEVELS+1];
    assign ug[0] = in_g;
    assign up[0] = in_p;

    for (genvar l = 0; l < LEVELS; l++) begin : g_up
        localparam int unsigned HALF = 1 << l;
        localparam int unsigned STEP = 2 << l;
        for (genvar i = 0; i < WIDTH; i++) begin : g_node
            if (((i + 1) % STEP) == 0) begin : g_cell
                assign {ug[l+1][i], up[l+1][i]} = gp_merge(
                    gp_t'{g: ug[l][i-HALF], p: up[l][i-HALF]},
                    gp_t'{g: ug[l][i],      p: up[l][i]});
            end else begin : g_wire
                assign ug[l+1][i] = ug[l][i];
                assign up[l+1][i] = up[l][i];
            end
        end
    end

    // Down-sweep: fill in the remaining prefixes, widest gap first.
    logic [WIDTH-1:0] dg [DOWN+1];
    logic [WIDTH-1:0] dp [DOWN+1];
    assign dg[0] = ug[LEVELS];
    assign dp[0] = up[LEVELS];

    for (genvar j = 0; j < DOWN; j++) begin : g_down
        localparam int unsigned D    = DOWN - 1 - j;
        localparam int unsigned HALF = 1 << D;
        localparam int unsigned STEP = 2 << D;
        for (genvar i = 0; i < WIDTH; i++) begin : g_node
            if ((i >= STEP) && (((i + 1) % STEP) == HALF)) begin : g_cell
                assign {dg[j+1][i], dp[j+1][i]} = gp_merge(
                    gp_t'{g: dg[j][i-HALF], p: dp[j][i-HALF]},
                    gp_t'{g: dg[j][i],      p: dp[j][i]});
            end else begin : g_wire
                assign dg[j+1][i] = dg[j][i];
                assign dp[j+1][i] = dp[j][i];
            end
        end
    end

    assign out_g = dg[DOWN];
    assign out_p = dp[DOWN];

endmodule

// File: rtl/sum_stage.sv
module sum_stage #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] bit_p,
    input  logic [WIDTH-1:0] pfx_g,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_out
);
    // Carry into bit i is the group generate ending at bit i-1.
    logic [WIDTH-1:0] carry_vec;
    assign carry_vec = {pfx_g[WIDTH-2:0], carry_in};
    assign sum_o     = bit_p ^ carry_vec;
    assign carry_out = pfx_g[WIDTH-1];

endmodule

// File: rtl/prefix_adder.sv
module prefix_adder #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned ARCH  = prefix_pkg::NET_FULL
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_out,
    output logic [WIDTH-1:0] grp_gen
);
    logic [WIDTH-1:0] bit_p;
    logic [WIDTH-1:0] leaf_g;
    logic [WIDTH-1:0] leaf_p;
    logic [WIDTH-1:0] pfx_p;

    bit_gp_gen #(.WIDTH(WIDTH)) u_leaf (
        .op_a     (op_a),
        .op_b     (op_b),
        .carry_in (carry_in),
        .bit_p    (bit_p),
        .leaf_g   (leaf_g),
        .leaf_p   (leaf_p)
    );

    if (ARCH == prefix_pkg::NET_SWEEP) begin : g_sweep
        sweep_prefix_net #(.WIDTH(WIDTH)) u_net (
            .in_g  (leaf_g),
            .in_p  (leaf_p),
            .out_g (grp_gen),
            .out_p (pfx_p)
        );
    end else begin : g_full
        full_prefix_net #(.WIDTH(WIDTH)) u_net (
            .in_g  (leaf_g),
            .in_p  (leaf_p),
            .out_g (grp_gen),
            .out_p (pfx_p)
        );
    end

    sum_stage #(.WIDTH(WIDTH)) u_sum (
        .bit_p     (bit_p),
        .pfx_g     (grp_gen),
        .carry_in  (carry_in),
        .sum_o     (sum_o),
        .carry_out (carry_out)
    );

endmodule

// File: rtl/prefix_adder_chk.sv
module prefix_adder_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum_o,
    input logic             carry_out,
    input logic [WIDTH-1:0] grp_gen,
    input logic [WIDTH-1:0] pfx_p
);
    logic [WIDTH:0] full_sum;
    assign full_sum = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

    always_comb begin
        assert_sum_R1: assert (sum_o == full_sum[WIDTH-1:0])
            else $error("sum_o mismatch");
        assert_cout_R2: assert (carry_out == full_sum[WIDTH])
            else $error("carry_out mismatch");
        assert_first_gen_R4: assert (grp_gen[0] ==
            ((op_a[0] & op_b[0]) | ((op_a[0] ^ op_b[0]) & carry_in)))
            else $error("grp_gen[0] mismatch");
        assert_no_prefix_prop_R4: assert (pfx_p == '0)
            else $error("prefix propagate set despite carry-in stage");
        for (int i = 1; i < WIDTH; i++) begin
            assert_chain_R5: assert (grp_gen[i] ==
                ((op_a[i] & op_b[i]) | ((op_a[i] ^ op_b[i]) & grp_gen[i-1])))
                else $error("grp_gen recurrence broken at %0d", i);
        end
        if ((op_a ^ op_b) == '1) begin
            assert_all_prop_R6: assert (grp_gen == {WIDTH{carry_in}})
                else $error("all-propagate carries wrong");
        end
    end

endmodule

bind prefix_adder prefix_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_o     (sum_o),
    .carry_out (carry_out),
    .grp_gen   (grp_gen),
    .pfx_p     (pfx_p)
);

// File: tb/tb_prefix_adder.sv
module tb_prefix_adder;
    localparam int unsigned W = 8;
    localparam int LIMIT = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] a, b;
    logic         ci;
    logic [W-1:0] s_f, s_s, gg_f, gg_s;
    logic         co_f, co_s;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    prefix_adder #(.WIDTH(W), .ARCH(0)) dut (
        .op_a(a), .op_b(b), .carry_in(ci),
        .sum_o(s_f), .carry_out(co_f), .grp_gen(gg_f));

    prefix_adder #(.WIDTH(W), .ARCH(1)) dut_sweep (
        .op_a(a), .op_b(b), .carry_in(ci),
        .sum_o(s_s), .carry_out(co_s), .grp_gen(gg_s));

    task automatic fail_line(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        fails++;
        $display("FAIL %s %s: actual=%0h expected=%0h (a=%0h b=%0h ci=%0b)",
                 req, what, act, exp, a, b, ci);
    endtask

    task automatic check_vec();
        logic [W:0] tot;
        logic [W-1:0] rip;
        logic c;
        tot = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        c = ci;
        for (int i = 0; i < W; i++) begin
            c = (a[i] & b[i]) | ((a[i] ^ b[i]) & c);
            rip[i] = c;
        end
        vectors++;
        // R1 sum, R2 carry-out, both shapes
        if (s_f != tot[W-1:0]) fail_line("R1", "sum full", 32'(s_f), 32'(tot[W-1:0]));
        if (s_s != tot[W-1:0]) fail_line("R1", "sum sweep", 32'(s_s), 32'(tot[W-1:0]));
        if (co_f != tot[W]) fail_line("R2", "cout full", 32'(co_f), 32'(tot[W]));
        if (co_s != tot[W]) fail_line("R2", "cout sweep", 32'(co_s), 32'(tot[W]));
        // R3 and R5 group generates against the ripple model
        if (gg_f != rip) fail_line("R3", "grp_gen full", 32'(gg_f), 32'(rip));
        if (gg_s != rip) fail_line("R5", "grp_gen sweep", 32'(gg_s), 32'(rip));
        // R4 lowest group generate
        if (gg_f[0] != ((a[0] & b[0]) | ((a[0] ^ b[0]) & ci)))
            fail_line("R4", "grp_gen[0]", 32'(gg_f[0]), 32'(rip[0]));
        // R6 all-propagate operands
        if ((a ^ b) == '1) begin
            if (gg_f != {W{ci}}) fail_line("R6", "grp_gen", 32'(gg_f), 32'({W{ci}}));
            if (s_f != {W{~ci}}) fail_line("R6", "sum", 32'(s_f), 32'({W{~ci}}));
        end
        // R7 shapes agree bit for bit
        if ({s_f, co_f, gg_f} != {s_s, co_s, gg_s})
            fail_line("R7", "shape mismatch", 32'({s_f, co_f, gg_f}), 32'({s_s, co_s, gg_s}));
    endtask

    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
        @(posedge clk);
        a = va; b = vb; ci = vc;
        @(negedge clk);
        check_vec();
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: zero operands give zero outputs (R1, R2, R3)
        @(negedge clk);
        check_vec();
        // Directed corners: full carry chain, R6 boundaries, top-bit carry
        apply(8'hFF, 8'h00, 1'b1);
        apply(8'hFF, 8'h00, 1'b0);
        apply(8'hAA, 8'h55, 1'b1);
        apply(8'h80, 8'h80, 1'b0);
        apply(8'hFF, 8'hFF, 1'b1);
        // Exhaustive sweep over both operands and the carry-in
        for (int ca = 0; ca < 2; ca++) begin
            for (int ia = 0; ia < 256; ia++) begin
                for (int ib = 0; ib < 256; ib++) begin
                    apply(ia[W-1:0], ib[W-1:0], ca[0]);
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == LIMIT && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule